// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller with Paged Configuration

This block is a byte-wide, register-mapped controller for 48 general-purpose lines, grouped as six ports of eight lines each. Line n belongs to port n/8, bit n%8. Writing a port's data register loads its open-drain output latch. A latch bit of 1 turns the pull-down on. Reading a port register returns the synchronised pin levels. A line used as an input keeps its latch bit at 0, so the read value shows the external level.

The three lowest ports can also detect edges on each line. For every such line there is a polarity bit, an enable bit and a latched pending flag. All three sets share one three-byte window, and a two-bit page field in the control register picks which set is visible. A summary register shows which ports hold pending events, and a single request output is raised while any event is pending. Software acknowledges an event by writing the enable byte with the bit cleared and then writing it again with the bit set.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, all output latches, the control register, polarities, enables and pending flags are zero, `irq_o` is 0, and every offset from 6 to 10 reads 0.
- R2: A write to offset p (0 to 5) whose lock bit is 0 loads `pin_drive[8p+7:8p]` with the write data on the next clock edge.
- R3: While control bit p (p in 0 to 5) is 1, writes to offset p leave the latch of port p unchanged. Once the bit is cleared, writes take effect again.
- R4: A read of offset p (0 to 5) returns `pin_in[8p+7:8p]` through a two-flop synchroniser. A change that is stable before a rising edge is visible after the second rising edge.
- R5: Offset 7 is the control register and reads back as written. Bits 7:6 hold the page (0 none, 1 polarity, 2 enable, 3 pending) and bits 5:0 hold the lock bits of ports 5 to 0.
- R6: Offsets 8, 9 and 10 address ports 0, 1 and 2 in the window. Page 1 reads and writes polarity, page 2 reads and writes enables, and page 3 reads the pending flags and ignores writes. Page 0 reads 0 and ignores writes. Offsets 11 to 15 read 0.
- R7: A polarity bit of 1 selects rising edges and 0 selects falling edges. A matching edge sets the pending flag only while the line's enable bit is 1. The flag appears after the third rising clock edge from the pin change.
- R8: Offset 6 bits 2:0 are the OR of the pending flags of ports 2, 1 and 0, and bits 7:3 read 0. `irq_o` is the OR of those three bits.
- R9: Writing 0 to an enable bit clears the line's pending flag. Writing 0 and then 1 acknowledges the event and leaves the flag clear, and the other ports keep their flags.
- R10: If an edge is captured in the same cycle as an enable write that clears its bit, the clear wins. An edge captured in the cycle where its enable goes from 0 to 1 is not recorded.
- R11: Edges on ports 3 to 5 never set a pending flag and never raise `irq_o`.
- R12: After all three enable bytes are written to 0, no line can raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Byte offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | External pin levels, asynchronous |
| pin_drive | output | 48 | Open-drain pull-down enables (output latches) |
| irq_o | output | 1 | Interrupt request, high while any event is pending |

## Verification
Edge capture and the acknowledge write to an enable byte can fall in the same clock cycle. When they do, the pending flag's next value depends on both the old and the new enable bit. The bench provokes this by changing a pin exactly two cycles before an enable write, so that the synchronised edge reaches the pending logic in the cycle the write lands. It does this once with the bit being cleared and once with the bit being armed. The result is judged by reading the pending page afterwards against the R10 rule. A behavioural reference model, compared every cycle, checks the read data, the request output and the latches.

// File: rtl/gpio_ec_pkg.sv
`timescale 1ns/1ps
package gpio_ec_pkg;
    localparam int PAGE_W = 2;

    typedef enum logic [PAGE_W-1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_EN   = 2'd2,
        PG_PEND = 2'd3
    } page_e;
endpackage

// File: rtl/gpio_ec_sync.sv
`timescale 1ns/1ps
module gpio_ec_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] safe
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = raw;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign safe = q.s2;
endmodule

// File: rtl/gpio_ec_edge.sv
`timescale 1ns/1ps
// One interrupt-capable port: edge detect against the previous level and latch pending flags.
module gpio_ec_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] en_now,
    input  logic [W-1:0] en_next,
    output logic [W-1:0] pend
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
    } edge_t;

    edge_t        d, q;
    logic [W-1:0] hit;

    always_comb begin
        hit    = (pol & lvl & ~q.prev) | (~pol & ~lvl & q.prev);
        d.prev = lvl;
        // An edge counts only when the line was already enabled; a zero written now wins.
        d.pend = (q.pend | (hit & en_now)) & en_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
    import gpio_ec_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int IRQ_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_drive,
    output logic                        irq_o
);
    localparam int LINES    = NUM_PORTS * PORT_W;
    localparam int SUM_OFS  = NUM_PORTS;
    localparam int CTRL_OFS = NUM_PORTS + 1;
    localparam int WIN_OFS  = NUM_PORTS + 2;

    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0] latch;
        logic [PORT_W-1:0]                ctrl;
        logic [IRQ_PORTS-1:0][PORT_W-1:0] pol;
        logic [IRQ_PORTS-1:0][PORT_W-1:0] en;
    } regs_t;

    regs_t                            d, q;
    page_e                            page;
    logic [LINES-1:0]                 sync_lvl;
    logic [IRQ_PORTS-1:0][PORT_W-1:0] pend;
    logic [IRQ_PORTS-1:0]             summary;
    logic [IRQ_PORTS*PORT_W-1:0]      pend_flat;
    logic [IRQ_PORTS*PORT_W-1:0]      en_flat;
    logic [PORT_W-1:0]                ctrl_now;

    assign page = page_e'(q.ctrl[PORT_W-1 -: PAGE_W]);

    gpio_ec_sync #(.W(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .safe (sync_lvl)
    );

    for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_edge
        gpio_ec_edge #(.W(PORT_W)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (sync_lvl[p*PORT_W +: PORT_W]),
            .pol    (q.pol[p]),
            .en_now (q.en[p]),
            .en_next(d.en[p]),
            .pend   (pend[p])
        );
        assign summary[p] = |pend[p];
    end

    // next-state decode of the register file
    always_comb begin
        d = q;
        if (bus_wr) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_addr == ADDR_W'(p) && !q.ctrl[p]) d.latch[p] = bus_wdata;
            end
            if (bus_addr == ADDR_W'(CTRL_OFS)) d.ctrl = bus_wdata;
            for (int p = 0; p < IRQ_PORTS; p++) begin
                if (bus_addr == ADDR_W'(WIN_OFS + p)) begin
                    if (page == PG_POL)     d.pol[p] = bus_wdata;
                    else if (page == PG_EN) d.en[p]  = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(p)) bus_rdata = sync_lvl[p*PORT_W +: PORT_W];
        end
        if (bus_addr == ADDR_W'(SUM_OFS))  bus_rdata = PORT_W'(summary);
        if (bus_addr == ADDR_W'(CTRL_OFS)) bus_rdata = q.ctrl;
        for (int p = 0; p < IRQ_PORTS; p++) begin
            if (bus_addr == ADDR_W'(WIN_OFS + p)) begin
                case (page)
                    PG_POL:  bus_rdata = q.pol[p];
                    PG_EN:   bus_rdata = q.en[p];
                    PG_PEND: bus_rdata = pend[p];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    assign pin_drive = q.latch;
    assign irq_o     = |summary;
    assign pend_flat = pend;
    assign en_flat   = q.en;
    assign ctrl_now  = q.ctrl;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_chk #(
    parameter int NUM_PORTS = 6,
    parameter int IRQ_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int ADDR_W    = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [PORT_W-1:0]           bus_wdata,
    input logic [PORT_W-1:0]           ctrl,
    input logic [IRQ_PORTS*PORT_W-1:0] en,
    input logic [IRQ_PORTS*PORT_W-1:0] pend,
    input logic [NUM_PORTS*PORT_W-1:0] drive
);
    localparam int                LW       = $clog2(PORT_W);
    localparam logic [ADDR_W-1:0] A_WIN0   = ADDR_W'(NUM_PORTS + 2);
    localparam logic [ADDR_W-1:0] A_NPORTS = ADDR_W'(NUM_PORTS);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && !ctrl[0]) |=> drive[PORT_W-1:0] == $past(bus_wdata));

    a_r3_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr < A_NPORTS && ctrl[LW'(bus_addr)]) |=> $stable(drive));

    a_r6_enable_only_page2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl[PORT_W-1 -: 2] != 2'd2) |=> $stable(en));

    a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(en)) == '0);

    a_r9_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_WIN0 && ctrl[PORT_W-1 -: 2] == 2'd2)
        |=> (pend[PORT_W-1:0] & ~$past(bus_wdata)) == '0);
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NUM_PORTS(NUM_PORTS),
    .IRQ_PORTS(IRQ_PORTS),
    .PORT_W   (PORT_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ctrl     (ctrl_now),
    .en       (en_flat),
    .pend     (pend_flat),
    .drive    (pin_drive)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in;
    logic [47:0] pin_drive;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_drive(pin_drive), .irq_o(irq_o)
    );

    // behavioural reference model
    logic [47:0] m_s1, m_s2, m_s3, m_latch;
    logic [7:0]  m_ctrl, n_ctrl;
    logic [23:0] m_pol, m_en, m_pend, n_pol, n_en;
    logic        hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_latch = '0;
            m_ctrl = '0; m_pol = '0; m_en = '0; m_pend = '0;
        end else begin
            n_ctrl = m_ctrl; n_pol = m_pol; n_en = m_en;
            if (bus_wr) begin
                if (bus_addr < 6) begin
                    if (!m_ctrl[bus_addr]) m_latch[int'(bus_addr)*8 +: 8] = bus_wdata;
                end else if (bus_addr == 7) begin
                    n_ctrl = bus_wdata;
                end else if (bus_addr >= 8 && bus_addr <= 10) begin
                    if (m_ctrl[7:6] == 2'd1)      n_pol[(int'(bus_addr)-8)*8 +: 8] = bus_wdata;
                    else if (m_ctrl[7:6] == 2'd2) n_en[(int'(bus_addr)-8)*8 +: 8]  = bus_wdata;
                end
            end
            for (int i = 0; i < 24; i++) begin
                hit = m_pol[i] ? (m_s2[i] && !m_s3[i]) : (!m_s2[i] && m_s3[i]);
                m_pend[i] = (m_pend[i] | (hit & m_en[i])) & n_en[i];
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            m_ctrl = n_ctrl; m_pol = n_pol; m_en = n_en;
        end
    end

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic [7:0] r;
        r = '0;
        if (a < 6) r = m_s2[int'(a)*8 +: 8];
        else if (a == 6) r = {5'b0, |m_pend[23:16], |m_pend[15:8], |m_pend[7:0]};
        else if (a == 7) r = m_ctrl;
        else if (a <= 10) begin
            case (m_ctrl[7:6])
                2'd1: r = m_pol[(int'(a)-8)*8 +: 8];
                2'd2: r = m_en[(int'(a)-8)*8 +: 8];
                2'd3: r = m_pend[(int'(a)-8)*8 +: 8];
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        if (a < 6)  return "R4";
        if (a == 6) return "R8";
        if (a == 7) return "R5";
        return "R6";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
            chk("R8", irq_o, |m_pend);
            chk("R2", pin_drive, m_latch);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
        tick(1);
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1", pin_drive, 48'h0);
        chk("R1", irq_o, 1'b0);
        rd(4'd6, 8'h00, "R1");
        rd(4'd7, 8'h00, "R1");
        rd(4'd8, 8'h00, "R1");
        rd(4'd10, 8'h00, "R1");
        // R2 latch writes
        wr(4'd0, 8'hA5);
        wr(4'd5, 8'h3C);
        chk("R2", pin_drive[7:0], 8'hA5);
        chk("R2", pin_drive[47:40], 8'h3C);
        // R3 / R5 locks and control readback
        wr(4'd7, 8'h02);
        rd(4'd7, 8'h02, "R5");
        wr(4'd1, 8'hFF);
        chk("R3", pin_drive[15:8], 8'h00);
        wr(4'd0, 8'h11);
        chk("R2", pin_drive[7:0], 8'h11);
        wr(4'd7, 8'h00);
        wr(4'd1, 8'h77);
        chk("R3", pin_drive[15:8], 8'h77);
        // R4 synchroniser latency
        pin_in[39:32] = 8'h5A;
        rd(4'd4, 8'h00, "R4");
        rd(4'd4, 8'h00, "R4");
        rd(4'd4, 8'h5A, "R4");
        // R6 window pages
        wr(4'd7, 8'h40);
        wr(4'd8, 8'hFF);
        rd(4'd8, 8'hFF, "R6");
        wr(4'd7, 8'h00);
        rd(4'd8, 8'h00, "R6");
        wr(4'd8, 8'h55);
        wr(4'd7, 8'h40);
        rd(4'd8, 8'hFF, "R6");
        rd(4'd11, 8'h00, "R6");
        // R7 rising edge with latency, R8 summary
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h01);
        wr(4'd7, 8'hC0);
        pin_in[0] = 1'b1;
        rd(4'd6, 8'h00, "R7");
        rd(4'd6, 8'h00, "R7");
        rd(4'd6, 8'h00, "R7");
        rd(4'd6, 8'h01, "R7");
        rd(4'd8, 8'h01, "R7");
        chk("R8", irq_o, 1'b1);
        // R7 falling polarity on port 1 line 1
        wr(4'd7, 8'h80);
        wr(4'd9, 8'h02);
        wr(4'd7, 8'hC0);
        pin_in[9] = 1'b1;
        tick(4);
        rd(4'd9, 8'h00, "R7");
        pin_in[9] = 1'b0;
        tick(4);
        rd(4'd9, 8'h02, "R7");
        rd(4'd6, 8'h03, "R8");
        // R6 pending page ignores writes
        wr(4'd9, 8'h00);
        rd(4'd9, 8'h02, "R6");
        // R9 acknowledge sequence
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h00);
        wr(4'd8, 8'h01);
        wr(4'd7, 8'hC0);
        rd(4'd8, 8'h00, "R9");
        rd(4'd6, 8'h02, "R9");
        chk("R9", irq_o, 1'b1);
        wr(4'd7, 8'h80);
        wr(4'd9, 8'h00);
        wr(4'd9, 8'h02);
        wr(4'd7, 8'hC0);
        rd(4'd6, 8'h00, "R9");
        chk("R9", irq_o, 1'b0);
        // R10a edge captured in the same cycle as a clearing write
        wr(4'd7, 8'h80);
        pin_in[0] = 1'b0;
        tick(4);
        pin_in[0] = 1'b1;
        tick(2);
        wr(4'd8, 8'h00);
        wr(4'd8, 8'h01);
        wr(4'd7, 8'hC0);
        rd(4'd8, 8'h00, "R10");
        // R10b edge captured in the same cycle as arming
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h00);
        pin_in[0] = 1'b0;
        tick(4);
        pin_in[0] = 1'b1;
        tick(2);
        wr(4'd8, 8'h01);
        wr(4'd7, 8'hC0);
        rd(4'd8, 8'h00, "R10");
        pin_in[0] = 1'b0;
        tick(4);
        pin_in[0] = 1'b1;
        tick(4);
        rd(4'd8, 8'h01, "R7");
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h00);
        // R11 ports 3 to 5 never interrupt
        wr(4'd8, 8'hFF);
        wr(4'd9, 8'hFF);
        wr(4'd10, 8'hFF);
        wr(4'd7, 8'hC0);
        pin_in[47:24] = ~pin_in[47:24];
        tick(4);
        pin_in[47:24] = ~pin_in[47:24];
        tick(4);
        chk("R11", irq_o, 1'b0);
        rd(4'd6, 8'h00, "R11");
        // R12 all enables cleared
        pin_in[23:0] = ~pin_in[23:0];
        tick(4);
        chk("R7", irq_o, 1'b1);
        wr(4'd7, 8'h80);
        wr(4'd8, 8'h00);
        wr(4'd9, 8'h00);
        wr(4'd10, 8'h00);
        chk("R12", irq_o, 1'b0);
        pin_in[23:0] = ~pin_in[23:0];
        tick(4);
        pin_in[23:0] = ~pin_in[23:0];
        tick(4);
        chk("R12", irq_o, 1'b0);
        rd(4'd6, 8'h00, "R12");
        finish_run();
    end
endmodule